// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the read and write command strobes of one IDE channel. Each accepted transfer request produces a strobe-low phase and then a strobe-high recovery phase. Both lengths are whole numbers of timing ticks, and both are taken from a packed 16-bit timing word for the selected drive. A tick is `TICK_CLKS` clock cycles; the design intent is a tick of about 30 ns. The timing word can also tell the block to stretch the strobe-low phase until the device raises its IORDY wait line.

Each of the `NUM_DRIVES` drive slots holds two timing words: one for PIO transfers and one for multiword DMA transfers. A DMA-start event on a drive makes its DMA word the live word. A DMA-end event makes its PIO word the live word again. A preset command loads one of three standard multiword DMA timing words into a drive's DMA slot. A read port returns any stored word.

Timing word layout (bit positions are behaviour): bits 15:8 hold the active tick count minus one. Bit 7 is reserved, is stored as 0 and reads as 0. Bit 6 enables IORDY sampling. Bits 5:0 hold the recovery tick count minus one.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset both strobes are high, `busy` and `done` are low, every PIO word reads `PIO_RESET` with bit 7 cleared, every DMA word reads 0x0707, and all drives use their PIO word.
- R2: A `req` seen while `busy` is low starts a transfer. In the next cycle the strobe goes low: `wr_strobe_n` if `is_write` was 1, otherwise `rd_strobe_n`. It stays low for (bits 15:8 + 1) x `TICK_CLKS` cycles, and the other strobe stays high throughout.
- R3: The recovery phase follows the strobe-low phase. It lasts (bits 5:0 + 1) x `TICK_CLKS` cycles, with both strobes high and `busy` high. `busy` is high for the whole transfer.
- R4: `done` is high for exactly one cycle: the first cycle after recovery, in which `busy` is already low.
- R5: When bit 6 of the word is 1 and `iordy` is sampled low at the end of the strobe-low count, the strobe stays low until the first clock edge that samples `iordy` high. When bit 6 is 0, `iordy` has no effect.
- R6: A `req` that arrives while `busy` is high is ignored. It does not change the running transfer's strobe choice or its durations.
- R7: A write with `cfg_we` stores `cfg_wdata` with bit 7 forced to 0. `cfg_kind` selects the slot: 0 for PIO, 1 for DMA. `rd_data` returns the word chosen by `rd_drive`/`rd_kind`, and its bit 7 is always 0.
- R8: A `dma_start` pulse for a drive makes every later transfer to that drive use its DMA word. A `dma_end` pulse makes them use its PIO word again. Other drives are not affected.
- R9: A `cfg_preset` pulse with `cfg_mode` 0, 1 or 2 loads 0x0707, 0x0201 or 0x0200 into the DMA word of `cfg_drive`. Mode 3 leaves the word unchanged.
- R10: A transfer uses the timing word captured when it was accepted. A configuration write during the transfer only affects later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write `cfg_wdata` into a timing slot |
| cfg_drive | input | DRV_W | Drive addressed by a write or preset |
| cfg_kind | input | 1 | Slot selector for writes: 0 PIO, 1 DMA |
| cfg_wdata | input | 16 | Timing word to store |
| cfg_preset | input | 1 | Load a standard DMA word |
| cfg_mode | input | 2 | DMA preset index, 0 to 2 |
| rd_drive | input | DRV_W | Drive for readback |
| rd_kind | input | 1 | Slot for readback: 0 PIO, 1 DMA |
| rd_data | output | 16 | Stored timing word |
| dma_start | input | 1 | Switch `dma_drive` to its DMA word |
| dma_end | input | 1 | Switch `dma_drive` back to its PIO word |
| dma_drive | input | DRV_W | Drive addressed by the DMA events |
| req | input | 1 | Transfer request |
| drive_sel | input | DRV_W | Drive for the request |
| is_write | input | 1 | 1 for a write strobe, 0 for a read strobe |
| iordy | input | 1 | Device ready line |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A wrong count or prescaler state shows up as a strobe-low or recovery length that is off by whole ticks. It becomes visible within one transfer, at the first strobe edge. A wrong live-word flag or a wrong captured word makes a transfer run with the other slot's lengths. A phase machine that fails to leave the wait state keeps `busy` high and never pulses `done`. The bench measures every phase length cycle by cycle and compares it with the value it computes from its own model of the stored words. It also reads the register slots back after writes and presets.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

    localparam int WORD_W = 16;
    localparam int ON_W   = 8;
    localparam int OFF_W  = 6;

    // bits 15:8 active-1, bit 7 reserved, bit 6 wait enable, bits 5:0 recovery-1
    typedef struct packed {
        logic [ON_W-1:0]  on_m1;
        logic             rsvd;
        logic             wait_en;
        logic [OFF_W-1:0] off_m1;
    } timing_word_t;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    function automatic timing_word_t scrub_word(input logic [WORD_W-1:0] raw);
        timing_word_t w;
        w      = timing_word_t'(raw);
        w.rsvd = 1'b0;
        return w;
    endfunction

    function automatic timing_word_t dma_preset(input logic [1:0] mode);
        case (mode)
            2'd0:    return timing_word_t'(16'h0707);
            2'd1:    return timing_word_t'(16'h0201);
            default: return timing_word_t'(16'h0200);
        endcase
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_strobe_pkg::*;
#(
    parameter int          NUM_DRIVES = 2,
    parameter int          DRV_W      = 1,
    parameter logic [15:0] PIO_RESET  = 16'h0909
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DRV_W-1:0] wr_drive,
    input  logic             wr_kind,
    input  logic [15:0]      wr_data,
    input  logic             preset_en,
    input  logic [1:0]       preset_mode,
    input  logic             dma_start,
    input  logic             dma_end,
    input  logic [DRV_W-1:0] dma_drive,
    input  logic [DRV_W-1:0] sel_drive,
    input  logic [DRV_W-1:0] rd_drive,
    input  logic             rd_kind,
    output timing_word_t     sel_word,
    output logic [15:0]      rd_data
);

    typedef struct packed {
        timing_word_t [NUM_DRIVES-1:0] pio;
        timing_word_t [NUM_DRIVES-1:0] dma;
        logic         [NUM_DRIVES-1:0] use_dma;
    } regs_t;

    regs_t regs_d, regs_q, regs_rst;

    always_comb begin
        regs_rst = '0;
        for (int i = 0; i < NUM_DRIVES; i++) begin
            regs_rst.pio[i] = scrub_word(PIO_RESET);
            regs_rst.dma[i] = dma_preset(2'd0);
        end
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_DRIVES; i++) begin
            if (int'(wr_drive) == i) begin
                if (preset_en && preset_mode != 2'd3)
                    regs_d.dma[i] = dma_preset(preset_mode);
                if (wr_en) begin
                    if (wr_kind) regs_d.dma[i] = scrub_word(wr_data);
                    else         regs_d.pio[i] = scrub_word(wr_data);
                end
            end
            if (int'(dma_drive) == i) begin
                if (dma_start) regs_d.use_dma[i] = 1'b1;
                if (dma_end)   regs_d.use_dma[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= regs_rst;
        else        regs_q <= regs_d;
    end

    always_comb begin
        sel_word = regs_q.pio[0];
        rd_data  = 16'h0000;
        for (int i = 0; i < NUM_DRIVES; i++) begin
            if (int'(sel_drive) == i)
                sel_word = regs_q.use_dma[i] ? regs_q.dma[i] : regs_q.pio[i];
            if (int'(rd_drive) == i)
                rd_data = rd_kind ? 16'(regs_q.dma[i]) : 16'(regs_q.pio[i]);
        end
    end

endmodule

// File: rtl/pio_tick_div.sv
module pio_tick_div #(
    parameter int TICK_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic tick
);

    localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [CW-1:0] TOP = CW'(TICK_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load || cnt_q == '0) cnt_d = TOP;
        else                     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TOP;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_strobe_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         is_write,
    input  timing_word_t word,
    input  logic         iordy,
    input  logic         tick,
    output logic         load,
    output logic         busy,
    output logic         rd_strobe_n,
    output logic         wr_strobe_n,
    output logic         done
);

    typedef struct packed {
        phase_e           phase;
        logic [ON_W-1:0]  on_cnt;
        logic [OFF_W-1:0] off_cnt;
        logic             wait_en;
        logic             waiting;
        logic             wr;
        logic             done;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req) begin
                    st_d.phase   = PH_ACTIVE;
                    st_d.on_cnt  = word.on_m1;
                    st_d.off_cnt = word.off_m1;
                    st_d.wait_en = word.wait_en;
                    st_d.waiting = 1'b0;
                    st_d.wr      = is_write;
                    load         = 1'b1;
                end
            end
            PH_ACTIVE: begin
                if (st_q.waiting) begin
                    if (iordy) begin
                        st_d.phase   = PH_RECOVER;
                        st_d.waiting = 1'b0;
                        load         = 1'b1;
                    end
                end else if (tick) begin
                    if (st_q.on_cnt != '0) begin
                        st_d.on_cnt = st_q.on_cnt - 1'b1;
                    end else if (st_q.wait_en && !iordy) begin
                        st_d.waiting = 1'b1;
                    end else begin
                        st_d.phase = PH_RECOVER;
                        load       = 1'b1;
                    end
                end
            end
            PH_RECOVER: begin
                if (tick) begin
                    if (st_q.off_cnt != '0) begin
                        st_d.off_cnt = st_q.off_cnt - 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign busy        = (st_q.phase != PH_IDLE);
    assign rd_strobe_n = !((st_q.phase == PH_ACTIVE) && !st_q.wr);
    assign wr_strobe_n = !((st_q.phase == PH_ACTIVE) &&  st_q.wr);
    assign done        = st_q.done;

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_strobe_pkg::*;
#(
    parameter int          NUM_DRIVES = 2,
    parameter int          TICK_CLKS  = 2,
    parameter logic [15:0] PIO_RESET  = 16'h0909,
    localparam int         DRV_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DRV_W-1:0] cfg_drive,
    input  logic             cfg_kind,
    input  logic [15:0]      cfg_wdata,
    input  logic             cfg_preset,
    input  logic [1:0]       cfg_mode,
    input  logic [DRV_W-1:0] rd_drive,
    input  logic             rd_kind,
    output logic [15:0]      rd_data,
    input  logic             dma_start,
    input  logic             dma_end,
    input  logic [DRV_W-1:0] dma_drive,
    input  logic             req,
    input  logic [DRV_W-1:0] drive_sel,
    input  logic             is_write,
    input  logic             iordy,
    output logic             rd_strobe_n,
    output logic             wr_strobe_n,
    output logic             busy,
    output logic             done
);

    timing_word_t live_word;
    logic         tick;
    logic         tick_load;

    pio_timing_regs #(
        .NUM_DRIVES (NUM_DRIVES),
        .DRV_W      (DRV_W),
        .PIO_RESET  (PIO_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_drive    (cfg_drive),
        .wr_kind     (cfg_kind),
        .wr_data     (cfg_wdata),
        .preset_en   (cfg_preset),
        .preset_mode (cfg_mode),
        .dma_start   (dma_start),
        .dma_end     (dma_end),
        .dma_drive   (dma_drive),
        .sel_drive   (drive_sel),
        .rd_drive    (rd_drive),
        .rd_kind     (rd_kind),
        .sel_word    (live_word),
        .rd_data     (rd_data)
    );

    pio_tick_div #(
        .TICK_CLKS (TICK_CLKS)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tick_load),
        .tick  (tick)
    );

    pio_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .is_write    (is_write),
        .word        (live_word),
        .iordy       (iordy),
        .tick        (tick),
        .load        (tick_load),
        .busy        (busy),
        .rd_strobe_n (rd_strobe_n),
        .wr_strobe_n (wr_strobe_n),
        .done        (done)
    );

endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        rd_strobe_n,
    input logic        wr_strobe_n,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strobe_n && !wr_strobe_n)); // R2

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy); // R2

    AST_BUSY_STARTS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!rd_strobe_n || !wr_strobe_n)); // R2

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe_n || !wr_strobe_n) |-> busy); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0); // R7

endmodule

bind pio_strobe_gen pio_strobe_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .rd_strobe_n (rd_strobe_n),
    .wr_strobe_n (wr_strobe_n),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data)
);

// File: tb/sim_pio_strobe_gen.sv
module sim_pio_strobe_gen;

    localparam int T = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_drive = '0;
    logic        cfg_kind = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_preset = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [0:0]  rd_drive = '0;
    logic        rd_kind = 1'b0;
    logic [15:0] rd_data;
    logic        dma_start = 1'b0;
    logic        dma_end = 1'b0;
    logic [0:0]  dma_drive = '0;
    logic        req = 1'b0;
    logic [0:0]  drive_sel = '0;
    logic        is_write = 1'b0;
    logic        iordy = 1'b1;
    logic        rd_strobe_n, wr_strobe_n, busy, done;

    pio_strobe_gen #(.NUM_DRIVES(2), .TICK_CLKS(T), .PIO_RESET(16'h0989)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_drive(cfg_drive),
        .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .cfg_preset(cfg_preset),
        .cfg_mode(cfg_mode), .rd_drive(rd_drive), .rd_kind(rd_kind),
        .rd_data(rd_data), .dma_start(dma_start), .dma_end(dma_end),
        .dma_drive(dma_drive), .req(req), .drive_sel(drive_sel),
        .is_write(is_write), .iordy(iordy), .rd_strobe_n(rd_strobe_n),
        .wr_strobe_n(wr_strobe_n), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [15:0] m_pio [2];
    logic [15:0] m_dma [2];
    bit          m_usedma [2];

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic int exp_active(input logic [15:0] w, input int k);
        int e;
        e = (int'(w[15:8]) + 1) * T;
        if (w[6] && k > e) e = k;
        return e;
    endfunction

    function automatic int exp_recover(input logic [15:0] w);
        return (int'(w[5:0]) + 1) * T;
    endfunction

    task automatic read_chk(input int drv, input bit kind, input string rq);
        logic [15:0] e;
        e = kind ? m_dma[drv] : m_pio[drv];
        @(negedge clk);
        rd_drive = drv[0:0];
        rd_kind  = kind;
        #1;
        chk(rd_data == e, rq, "readback", int'(rd_data), int'(e));
    endtask

    task automatic cfg_write(input int drv, input bit kind, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_drive = drv[0:0]; cfg_kind = kind; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (kind) m_dma[drv] = data & 16'hFF7F;
        else      m_pio[drv] = data & 16'hFF7F;
    endtask

    task automatic preset(input int drv, input logic [1:0] mode);
        @(negedge clk);
        cfg_preset = 1'b1; cfg_drive = drv[0:0]; cfg_mode = mode;
        @(negedge clk);
        cfg_preset = 1'b0;
        case (mode)
            2'd0: m_dma[drv] = 16'h0707;
            2'd1: m_dma[drv] = 16'h0201;
            2'd2: m_dma[drv] = 16'h0200;
            default: ;
        endcase
    endtask

    task automatic dma_evt(input int drv, input bit start);
        @(negedge clk);
        dma_drive = drv[0:0];
        dma_start = start;
        dma_end   = !start;
        @(negedge clk);
        dma_start = 1'b0;
        dma_end   = 1'b0;
        m_usedma[drv] = start;
    endtask

    task automatic xfer(input int drv, input bit wr, input int k,
                        input bit poke_req, input bit poke_cfg, input string rq);
        logic [15:0] w, nw;
        int ea, er, act, rec, guard;
        bit bad;
        w  = m_usedma[drv] ? m_dma[drv] : m_pio[drv];
        nw = ~w;
        ea = exp_active(w, k);
        er = exp_recover(w);
        @(negedge clk);
        iordy = (k == 0); req = 1'b1; drive_sel = drv[0:0]; is_write = wr;
        @(negedge clk);
        req = 1'b0;
        act = 0; rec = 0; guard = 0; bad = 0;
        while (((wr ? wr_strobe_n : rd_strobe_n) == 1'b0) && guard < 4000) begin
            act++; guard++;
            if ((wr ? rd_strobe_n : wr_strobe_n) == 1'b0) bad = 1;
            if (act == k) iordy = 1'b1;
            if (poke_req) begin
                req = (act == 1); drive_sel = ~drv[0:0]; is_write = !wr;
            end
            if (poke_cfg) begin
                cfg_we = (act == 1); cfg_drive = drv[0:0];
                cfg_kind = m_usedma[drv]; cfg_wdata = nw;
            end
            @(negedge clk);
        end
        req = 1'b0; cfg_we = 1'b0; iordy = 1'b1;
        while (busy && guard < 8000) begin
            rec++; guard++;
            if (!rd_strobe_n || !wr_strobe_n) bad = 1;
            @(negedge clk);
        end
        chk(act == ea, rq, "strobe-low cycles", act, ea);
        chk(rec == er, rq, "recovery cycles", rec, er);
        chk(!bad, rq, "idle strobe stayed high", int'(bad), 0);
        chk(done && !busy, "R4", "done at end", int'({done, busy}), 2);
        @(negedge clk);
        chk(!done, "R4", "done width", int'(done), 0);
        if (poke_cfg) begin
            if (m_usedma[drv]) m_dma[drv] = nw & 16'hFF7F;
            else               m_pio[drv] = nw & 16'hFF7F;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            m_pio[i] = 16'h0909;
            m_dma[i] = 16'h0707;
            m_usedma[i] = 0;
        end
        repeat (4) @(negedge clk);
        chk(rd_strobe_n && wr_strobe_n && !busy && !done, "R1", "reset outputs",
            int'({rd_strobe_n, wr_strobe_n, busy, done}), 12);
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            read_chk(i, 1'b0, "R1");
            read_chk(i, 1'b1, "R1");
        end
        xfer(0, 1'b0, 0, 0, 0, "R1");

        cfg_write(0, 1'b0, 16'h0203);
        read_chk(0, 1'b0, "R7");
        xfer(0, 1'b0, 0, 0, 0, "R2");
        xfer(0, 1'b1, 0, 0, 0, "R3");

        cfg_write(0, 1'b0, 16'h01C2);
        read_chk(0, 1'b0, "R7");
        xfer(0, 1'b0, 20, 0, 0, "R5");
        xfer(0, 1'b1, 0, 0, 0, "R5");
        xfer(0, 1'b0, 3, 0, 0, "R5");
        cfg_write(1, 1'b0, 16'h0001);
        xfer(1, 1'b1, 30, 0, 0, "R5");

        cfg_write(1, 1'b0, 16'h0402);
        xfer(1, 1'b0, 0, 1, 0, "R6");
        xfer(1, 1'b1, 0, 1, 0, "R6");
        xfer(1, 1'b0, 0, 0, 1, "R10");
        read_chk(1, 1'b0, "R10");
        xfer(1, 1'b0, 0, 0, 0, "R10");

        for (int m = 0; m < 4; m++) begin
            preset(1, 2'(3 - m));
            read_chk(1, 1'b1, "R9");
        end
        preset(0, 2'd1);
        read_chk(0, 1'b1, "R9");

        cfg_write(0, 1'b0, 16'h0300);
        cfg_write(1, 1'b0, 16'h0005);
        dma_evt(0, 1'b1);
        xfer(0, 1'b0, 0, 0, 0, "R8");
        xfer(1, 1'b0, 0, 0, 0, "R8");
        dma_evt(0, 1'b0);
        xfer(0, 1'b1, 0, 0, 0, "R8");

        for (int n = 0; n < 40; n++) begin
            int d, act;
            d = int'($urandom_range(0, 1));
            act = int'($urandom_range(0, 9));
            if (act < 3) begin
                cfg_write(d, 1'($urandom_range(0, 1)),
                          {8'($urandom_range(0, 12)), 2'($urandom_range(0, 3)),
                           6'($urandom_range(0, 20))});
            end else if (act == 3) begin
                dma_evt(d, 1'($urandom_range(0, 1)));
            end else if (act == 4) begin
                preset(d, 2'($urandom_range(0, 3)));
                read_chk(d, 1'b1, "R9");
            end
            xfer(d, 1'($urandom_range(0, 1)), int'($urandom_range(0, 40)),
                 1'($urandom_range(0, 1)), 1'b0, "R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule